// File: doc/BRIEF.md
# Capture Timer with Halfword Streaming to Memory

This block has a 16-bit free-running counter and one capture channel. A rising edge on the capture pin is first synchronised with two flops. The edge then latches the counter into a capture register and sets a pending flag. When streaming is enabled, the same edge also hands the captured halfword to a small transfer engine. The engine writes it to memory through a valid/ready write port, with no processor involvement.

Software programs a destination base address and a transfer count written as N minus 1. Writing the count arms the engine. Each accepted write then advances the destination by two bytes and uses up one transfer. The data source is always the captured value, so no source address is ever stepped. Each capture is a separate single-item request.

After the N-th write the engine raises a done flag. It then ignores requests until the count is written again. If a second capture arrives while one is still pending, the block sets an overrun flag and overwrites the capture register. The halfword already offered to memory is left unchanged.

Top module: `capdma_top`

## Requirements
- R1: After reset, the counter, capture register, pending flag, overrun flag, done flag and `mem_valid` are all zero.
- R2: The counter increases by one every clock cycle while control bit 0 (run) is 1, and holds its value while that bit is 0.
- R3: A rising edge on `cap_pin` sets `cap_pend` and loads `cap_value` on the third rising clock edge after the pin is first sampled high. The value loaded is the counter value of the cycle before that edge.
- R4: A transfer is requested only if control bit 1 (stream enable) is 1 and the capture takes `cap_pend` from 0 to 1. With stream enable at 0, `mem_valid` stays low.
- R5: `mem_valid` rises in the same cycle as `cap_pend`, and `mem_wdata` carries the captured halfword. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold steady.
- R6: The first write after arming goes to the base written at register 1. Each accepted write (`mem_valid` and `mem_ready` both high) raises `mem_addr` by 2.
- R7: An accepted write clears `cap_pend`.
- R8: Writing register 3 clears flags where a bit is 1: bit 0 clears the pending flag, bit 1 the overrun flag and bit 2 the done flag.
- R9: A capture while `cap_pend` is 1 sets `cap_overrun`, overwrites `cap_value`, issues no new request and leaves the offered `mem_wdata` unchanged.
- R10: Writing register 2 with N minus 1 arms the engine for N transfers and clears done. After the N-th accepted write, `xfer_done` is 1 and later captures produce no `mem_valid` until register 2 is written again.
- R11: A falling edge on `cap_pin`, or the pin staying high, causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 destination base, 2 count (N-1), 3 flag clear |
| cfg_wdata | input | 16 | Register write data |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_count | output | 16 | Free-running counter value |
| cap_value | output | 16 | Last captured counter value |
| cap_pend | output | 1 | Capture pending flag |
| cap_overrun | output | 1 | Overrun flag |
| xfer_done | output | 1 | All programmed transfers completed |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Halfword to write |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
The bench stalls `mem_ready` and then fires a second capture while the first write is still offered. A design that re-sampled the capture register would corrupt the pending halfword, and one that queued a second request would emit an extra write. It walks the destination across a full run of N writes and re-arms the engine. This exposes an off-by-one in the N minus 1 count, a missing step of 2, or a pointer that is not reloaded from the base. It also keeps the pin high across a flag clear and then drops it. A level-sensitive or falling-edge detector would produce spurious captures.

// File: rtl/capdma_pkg.sv
package capdma_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_DEST   = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_DMA_BIT = 1;
  localparam int ST_PEND_BIT  = 0;
  localparam int ST_OVR_BIT   = 1;
  localparam int ST_DONE_BIT  = 2;
  localparam int HALF_W       = 16;
  localparam int HALF_BYTES   = 2;
endpackage

// File: rtl/capdma_sync.sv
module capdma_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sh_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[TOP-1:0], pin_i};
      last_q <= sh_q[TOP];
    end
  end

  assign rise_o = sh_q[TOP] & ~last_q;
endmodule

// File: rtl/capdma_regs.sv
module capdma_regs
  import capdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              run_o,
  output logic              dma_en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              arm_o,
  output logic              clr_pend_o,
  output logic              clr_ovr_o,
  output logic              clr_done_o
);
  reg_sel_e sel;
  logic     wr_status;

  assign sel       = reg_sel_e'(cfg_addr);
  assign wr_status = cfg_we && (sel == REG_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o    <= 1'b0;
      dma_en_o <= 1'b0;
      base_o   <= '0;
    end else if (cfg_we) begin
      if (sel == REG_CTRL) begin
        run_o    <= cfg_wdata[CTRL_RUN_BIT];
        dma_en_o <= cfg_wdata[CTRL_DMA_BIT];
      end
      if (sel == REG_DEST) base_o <= cfg_wdata[ADDR_W-1:0];
    end
  end

  assign arm_o      = cfg_we && (sel == REG_COUNT);
  assign count_o    = cfg_wdata[CNT_W-1:0];
  assign clr_pend_o = wr_status && cfg_wdata[ST_PEND_BIT];
  assign clr_ovr_o  = wr_status && cfg_wdata[ST_OVR_BIT];
  assign clr_done_o = wr_status && cfg_wdata[ST_DONE_BIT];
endmodule

// File: rtl/capdma_capture.sv
module capdma_capture
  import capdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              dma_en_i,
  input  logic              rise_i,
  input  logic              ack_i,
  input  logic              clr_pend_i,
  input  logic              clr_ovr_i,
  output logic [HALF_W-1:0] cnt_o,
  output logic [HALF_W-1:0] cap_o,
  output logic              pend_o,
  output logic              ovr_o,
  output logic              req_o,
  output logic [HALF_W-1:0] req_data_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] cap_q;
  logic              pend_q;
  logic              ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rise_i) begin
        cap_q  <= cnt_q;
        pend_q <= 1'b1;
      end else if (ack_i || clr_pend_i) begin
        pend_q <= 1'b0;
      end
      if (rise_i && pend_q) ovr_q <= 1'b1;
      else if (clr_ovr_i)   ovr_q <= 1'b0;
    end
  end

  assign req_o      = rise_i && dma_en_i && !pend_q;
  assign req_data_o = cnt_q;
  assign cnt_o      = cnt_q;
  assign cap_o      = cap_q;
  assign pend_o     = pend_q;
  assign ovr_o      = ovr_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run_i |=> cnt_q == $past(cnt_q) + HALF_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(cnt_q)); // R2
  AST_OVR_ON_RECAPTURE: assert property (@(posedge clk) disable iff (rst)
    rise_i && pend_q |=> ovr_q && pend_q); // R9
  AST_PEND_CLR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_i && !rise_i |=> !pend_q); // R7
endmodule

// File: rtl/capdma_xfer.sv
module capdma_xfer
  import capdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              clr_done_i,
  input  logic              req_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HALF_W-1:0] mem_wdata_o,
  output logic              ack_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              armed_q;
  logic              valid_q;
  logic [HALF_W-1:0] data_q;
  logic              done_q;
  logic              ack;

  assign ack = valid_q && mem_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else if (arm_i) begin
      ptr_q   <= base_i;
      rem_q   <= count_i;
      armed_q <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (ack) begin
        valid_q <= 1'b0;
        ptr_q   <= ptr_q + ADDR_W'(HALF_BYTES);
        if (rem_q == '0) begin
          armed_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          rem_q <= rem_q - CNT_W'(1);
        end
      end else if (req_i && armed_q && !valid_q) begin
        valid_q <= 1'b1;
        data_q  <= data_i;
      end
      if (clr_done_i) done_q <= 1'b0;
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = data_q;
  assign ack_o       = ack;
  assign done_o      = done_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    valid_q && !mem_ready_i && !arm_i |=>
      valid_q && $stable(ptr_q) && $stable(data_q)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ack && !arm_i |=> ptr_q == $past(ptr_q) + ADDR_W'(HALF_BYTES)); // R6
  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_q && !arm_i |=> !valid_q); // R10
endmodule

// File: rtl/capdma_top.sv
module capdma_top
  import capdma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int CFG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cap_pin,
  output logic [HALF_W-1:0] tmr_count,
  output logic [HALF_W-1:0] cap_value,
  output logic              cap_pend,
  output logic              cap_overrun,
  output logic              xfer_done,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_wdata,
  input  logic              mem_ready
);
  logic              run, dma_en, arm, clr_pend, clr_ovr, clr_done;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  count;
  logic              rise, req, ack;
  logic [HALF_W-1:0] req_data;

  capdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .run_o(run), .dma_en_o(dma_en), .base_o(base),
    .count_o(count), .arm_o(arm), .clr_pend_o(clr_pend),
    .clr_ovr_o(clr_ovr), .clr_done_o(clr_done)
  );

  capdma_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(cap_pin), .rise_o(rise)
  );

  capdma_capture u_cap (
    .clk(clk), .rst(rst), .run_i(run), .dma_en_i(dma_en), .rise_i(rise),
    .ack_i(ack), .clr_pend_i(clr_pend), .clr_ovr_i(clr_ovr),
    .cnt_o(tmr_count), .cap_o(cap_value), .pend_o(cap_pend),
    .ovr_o(cap_overrun), .req_o(req), .req_data_o(req_data)
  );

  capdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst(rst), .arm_i(arm), .base_i(base), .count_i(count),
    .clr_done_i(clr_done), .req_i(req), .data_i(req_data),
    .mem_ready_i(mem_ready), .mem_valid_o(mem_valid), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .ack_o(ack), .done_o(xfer_done)
  );
endmodule

// File: tb/capdma_top_bench.sv
`timescale 1ns/1ps
module capdma_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        cap_pin = 1'b0;
  logic        mem_ready = 1'b0;
  logic [15:0] tmr_count, cap_value, mem_addr, mem_wdata;
  logic        cap_pend, cap_overrun, xfer_done, mem_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  capdma_top u_capdma_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cap_pin(cap_pin), .tmr_count(tmr_count),
    .cap_value(cap_value), .cap_pend(cap_pend), .cap_overrun(cap_overrun),
    .xfer_done(xfer_done), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 16'd0;
  endtask

  // Raise the pin; returns the counter value the capture must latch.
  task automatic capture(output logic [15:0] exp);
    cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp = tmr_count;
    @(negedge clk);
  endtask

  task automatic drop_pin();
    cap_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tmr_count == 0, "R1 count", tmr_count, 0);
    chk(cap_value == 0, "R1 cap", cap_value, 0);
    chk({cap_pend, cap_overrun, xfer_done, mem_valid} == 4'b0, "R1 flags",
        {cap_pend, cap_overrun, xfer_done, mem_valid}, 0);
  endtask

  task automatic t_counter();
    logic [15:0] a;
    wr(2'd0, 16'h0001);
    a = tmr_count;
    repeat (5) @(negedge clk);
    chk(tmr_count == a + 16'd5, "R2 run", tmr_count, a + 16'd5);
    wr(2'd0, 16'h0000);
    a = tmr_count;
    repeat (4) @(negedge clk);
    chk(tmr_count == a, "R2 hold", tmr_count, a);
    wr(2'd0, 16'h0001);
  endtask

  task automatic t_capture_no_stream();
    logic [15:0] exp, held;
    capture(exp);
    chk(cap_pend == 1'b1, "R3 pend", cap_pend, 1);
    chk(cap_value == exp, "R3 value", cap_value, exp);
    chk(mem_valid == 1'b0, "R4 no request when disabled", mem_valid, 0);
    held = cap_value;
    wr(2'd3, 16'h0001);
    chk(cap_pend == 1'b0, "R8 pend clear", cap_pend, 0);
    repeat (4) @(negedge clk);
    chk(cap_pend == 1'b0, "R11 level high", cap_pend, 0);
    drop_pin();
    repeat (3) @(negedge clk);
    chk(cap_pend == 1'b0, "R11 falling edge", cap_pend, 0);
    chk(cap_value == held, "R11 value kept", cap_value, held);
    chk(mem_valid == 1'b0, "R4 still idle", mem_valid, 0);
  endtask

  task automatic one_xfer(input logic [15:0] exp_addr, input string tag);
    logic [15:0] exp;
    capture(exp);
    chk(mem_valid == 1'b1, {tag, " R5 valid"}, mem_valid, 1);
    chk(mem_wdata == exp, {tag, " R5 data"}, mem_wdata, exp);
    chk(mem_addr == exp_addr, {tag, " R6 addr"}, mem_addr, exp_addr);
    repeat (3) @(negedge clk);
    chk(mem_valid && mem_wdata == exp && mem_addr == exp_addr, {tag, " R5 stall hold"},
        {mem_valid, mem_addr}, {1'b1, exp_addr});
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(mem_valid == 1'b0, {tag, " R6 accept"}, mem_valid, 0);
    chk(cap_pend == 1'b0, {tag, " R7 pend cleared"}, cap_pend, 0);
    chk(mem_addr == exp_addr + 16'd2, {tag, " R6 step"}, mem_addr, exp_addr + 16'd2);
    drop_pin();
  endtask

  task automatic t_stream_run();
    logic [15:0] exp;
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0003);
    one_xfer(16'h0100, "x0");
    chk(xfer_done == 1'b0, "R10 not done early", xfer_done, 0);
    one_xfer(16'h0102, "x1");
    one_xfer(16'h0104, "x2");
    chk(xfer_done == 1'b1, "R10 done after N", xfer_done, 1);
    capture(exp);
    repeat (2) @(negedge clk);
    chk(mem_valid == 1'b0, "R10 request ignored", mem_valid, 0);
    chk(cap_value == exp, "R10 capture still latched", cap_value, exp);
    wr(2'd3, 16'h0001);
    drop_pin();
    wr(2'd2, 16'd0);
    chk(xfer_done == 1'b0, "R10 rearm clears done", xfer_done, 0);
    one_xfer(16'h0100, "rearm");
    chk(xfer_done == 1'b1, "R10 single done", xfer_done, 1);
    wr(2'd3, 16'h0004);
    chk(xfer_done == 1'b0, "R8 done clear", xfer_done, 0);
  endtask

  task automatic t_overrun();
    logic [15:0] first, second;
    wr(2'd1, 16'h0200);
    wr(2'd2, 16'd3);
    capture(first);
    chk(mem_valid && mem_wdata == first, "R5 first offer", mem_wdata, first);
    drop_pin();
    capture(second);
    chk(cap_overrun == 1'b1, "R9 overrun set", cap_overrun, 1);
    chk(cap_value == second, "R9 overwritten", cap_value, second);
    chk(mem_wdata == first, "R9 offered data kept", mem_wdata, first);
    mem_ready = 1'b1;
    @(negedge clk);
    chk(mem_valid == 1'b0, "R9 accepted", mem_valid, 0);
    repeat (3) @(negedge clk);
    mem_ready = 1'b0;
    chk(mem_valid == 1'b0, "R9 no second request", mem_valid, 0);
    chk(mem_addr == 16'h0202, "R6 after overrun", mem_addr, 16'h0202);
    wr(2'd3, 16'h0002);
    chk(cap_overrun == 1'b0, "R8 overrun clear", cap_overrun, 0);
    drop_pin();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_counter();
    t_capture_no_stream();
    t_stream_run();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule